// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter with Status Codes

This block is a byte-oriented master for a two-wire open-drain serial bus (I2C-style), driven by a host through three small registers. The host requests a START and the block issues it once the bus is free. It then shifts out an address byte and further data bytes MSB first and samples the acknowledge bit after each byte. It finishes with either a repeated START or a STOP. After every bus event the block raises an interrupt flag and publishes a fixed hexadecimal status code. It then holds SCL low until the host clears the flag, so software paces the transfer one event at a time.

The SCL rate comes from a 3-bit select. Seven codes pick a fixed divider of the system clock. The eighth code counts pulses on an external timer-overflow input, so that software can program arbitrary slow rates. Each SCL period is split into a low half and a high half of equal length. SDA is updated only while SCL is low, except for the START and STOP edges.

Top module: `twi_mstx`

## Requirements
- R1: After reset, control (address 0) reads 00h, status (address 2) reads F8h, `irq` is low and neither bus line is pulled low.
- R2: Control layout is rate select [7:5], enable [4], start [3], stop [2], acknowledge-enable [1] (stored only) and flag [0]. With enable and start set and the flag clear, the block waits until both lines are high. It then pulls SDA low while SCL is high, sets the flag and reports status 08h.
- R3: After the flag is cleared with start and stop at zero, the data register (address 1) is sent MSB first. After the first byte following a START, status is 18h if the receiver pulled SDA low in the ninth bit and 20h otherwise.
- R4: For each later byte, status is 28h on acknowledge and 30h on no acknowledge.
- R5: While the flag is set, SCL stays pulled low and neither the status nor the bus changes.
- R6: Clearing the flag with start set and stop clear produces a repeated START and status 10h.
- R7: Clearing the flag with stop set makes SDA rise while SCL is high. The stop bit then clears by itself, both lines are released, the flag stays clear and status reads F8h.
- R8: When stop and start are both set as the flag is cleared, the STOP is issued first and a fresh START follows with status 08h.
- R9: For rate codes 0 to 6, SCL stays high for half of 128, 112, 96, 80, 480, 60 or 30 clock cycles respectively.
- R10: For rate code 7, SCL stays high for 48 pulses of the overflow input, that is half of a 96-pulse bit period.
- R11: With enable at zero a start request is ignored. Writing 1 to the flag bit never sets it.
- R12: SDA changes while SCL is high only as a START (falling) or a STOP (rising) edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_tick | input | 1 | One-cycle timer overflow pulse, used by rate code 7 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
A STOP request and a START request can land in the same flag-clear write. The block must order them as STOP then START. The bench provokes this by writing both bits together after an acknowledged address. It judges the result by counting one STOP and one new START edge on the bus, with status 08h afterwards. A START request can also arrive while another device holds SCL low. The bench pulls SCL low from outside during the request and confirms that the flag stays low and no START edge appears until the line is released.

// File: rtl/twi_mstx_pkg.sv
package twi_mstx_pkg;

  localparam int unsigned HALF_W    = 9;   // holds the largest half period (240)
  localparam int unsigned TMR_HALF  = 48;  // overflow pulses per half bit
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned BIT_W     = $clog2(BYTE_BITS + 1);

  localparam logic [1:0] RA_CTL  = 2'd0;
  localparam logic [1:0] RA_DAT  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  localparam logic [7:0] SC_START  = 8'h08;
  localparam logic [7:0] SC_RSTART = 8'h10;
  localparam logic [7:0] SC_ADR_AK = 8'h18;
  localparam logic [7:0] SC_ADR_NK = 8'h20;
  localparam logic [7:0] SC_DAT_AK = 8'h28;
  localparam logic [7:0] SC_DAT_NK = 8'h30;
  localparam logic [7:0] SC_NONE   = 8'hF8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI,
    ST_RSA, ST_RSB, ST_SPA, ST_SPB, ST_SPC
  } twi_state_e;

  // Half of the SCL period, in clocks (codes 0..6) or overflow pulses (code 7)
  function automatic logic [HALF_W-1:0] half_len(input logic [2:0] sel);
    logic [HALF_W:0] full;
    case (sel)
      3'd0:    full = 10'd128;
      3'd1:    full = 10'd112;
      3'd2:    full = 10'd96;
      3'd3:    full = 10'd80;
      3'd4:    full = 10'd480;
      3'd5:    full = 10'd60;
      3'd6:    full = 10'd30;
      default: full = 10'(2 * TMR_HALF);
    endcase
    return full[HALF_W:1];
  endfunction

endpackage

// File: rtl/twi_mstx_rate.sv
module twi_mstx_rate
  import twi_mstx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       ovf_tick,
  output logic       half_tick
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;
  logic              step;

  assign lim       = half_len(sel) - 1'b1;
  assign step      = (sel == 3'd7) ? ovf_tick : 1'b1;
  assign half_tick = run && step && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_tick) cnt <= '0;
    else if (step)             cnt <= cnt + 1'b1;
  end

  // R9
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= lim)) else $error("half counter beyond limit");

endmodule

// File: rtl/twi_mstx_seq.sv
module twi_mstx_seq
  import twi_mstx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sta,
  input  logic       sto,
  input  logic       flag,
  input  logic [7:0] tx_byte,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       half_tick,
  output logic       run,
  output logic       scl_low,
  output logic       sda_low,
  output logic       set_flag,
  output logic [7:0] set_code,
  output logic       stop_done
);

  twi_state_e       state;
  logic [7:0]       shifter;
  logic [BIT_W-1:0] bitn;
  logic             addr_ph;
  logic             rep;
  logic             hold_sda_low;

  logic bus_free;
  logic ack_bit;
  logic ack_bit_end;
  logic start_end;

  assign bus_free    = scl_in && sda_in;
  assign ack_bit     = (bitn == BIT_W'(BYTE_BITS));
  assign ack_bit_end = (state == ST_BHI) && half_tick && ack_bit;
  assign start_end   = (state == ST_START) && half_tick;

  assign run     = !(state inside {ST_IDLE, ST_HOLD});
  assign scl_low = state inside {ST_HOLD, ST_BLO, ST_RSA, ST_SPA};

  always_comb begin
    case (state)
      ST_START:        sda_low = 1'b1;
      ST_HOLD:         sda_low = hold_sda_low;
      ST_BLO, ST_BHI:  sda_low = !ack_bit && !shifter[7];
      ST_SPA, ST_SPB:  sda_low = 1'b1;
      default:         sda_low = 1'b0;
    endcase
  end

  assign set_flag  = start_end || ack_bit_end;
  assign stop_done = (state == ST_SPC) && half_tick;

  always_comb begin
    if (state == ST_START) set_code = rep ? SC_RSTART : SC_START;
    else if (addr_ph)      set_code = sda_in ? SC_ADR_NK : SC_ADR_AK;
    else                   set_code = sda_in ? SC_DAT_NK : SC_DAT_AK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      shifter      <= '0;
      bitn         <= '0;
      addr_ph      <= 1'b0;
      rep          <= 1'b0;
      hold_sda_low <= 1'b0;
    end else if (!en) begin
      state        <= ST_IDLE;
      rep          <= 1'b0;
      hold_sda_low <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  if (sta && !flag && bus_free) state <= ST_START;
        ST_START: if (half_tick) begin
                    state        <= ST_HOLD;
                    hold_sda_low <= 1'b1;
                    addr_ph      <= 1'b1;
                    rep          <= 1'b0;
                  end
        ST_HOLD:  if (!flag) begin
                    if (sto)      state <= ST_SPA;
                    else if (sta) begin state <= ST_RSA; rep <= 1'b1; end
                    else begin
                      shifter <= tx_byte;
                      bitn    <= '0;
                      state   <= ST_BLO;
                    end
                  end
        ST_BLO:   if (half_tick) state <= ST_BHI;
        ST_BHI:   if (half_tick) begin
                    if (ack_bit) begin
                      state        <= ST_HOLD;
                      hold_sda_low <= 1'b0;
                      addr_ph      <= 1'b0;
                    end else begin
                      shifter <= {shifter[6:0], 1'b0};
                      bitn    <= bitn + 1'b1;
                      state   <= ST_BLO;
                    end
                  end
        ST_RSA:   if (half_tick) state <= ST_RSB;
        ST_RSB:   if (half_tick) state <= ST_START;
        ST_SPA:   if (half_tick) state <= ST_SPB;
        ST_SPB:   if (half_tick) state <= ST_SPC;
        ST_SPC:   if (half_tick) begin
                    state        <= ST_IDLE;
                    hold_sda_low <= 1'b0;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R12
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sda_low != $past(sda_low)) && !scl_low && !$past(scl_low))
      |-> (state inside {ST_START, ST_SPC}))
    else $error("SDA moved while SCL high outside START/STOP");

  // R2
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) == ST_IDLE) |-> $past(bus_free))
    else $error("START issued on a busy bus");

endmodule

// File: rtl/twi_mstx.sv
module twi_mstx
  import twi_mstx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_tick,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);

  logic [2:0] rate_q;
  logic       en_q, sta_q, sto_q, aa_q, flag_q;
  logic [7:0] dat_q;
  logic [7:0] code_q;

  logic       run, half_tick, set_flag, stop_done;
  logic [7:0] set_code;
  logic       ctl_wr, dat_wr;

  assign ctl_wr = reg_we && (reg_addr == RA_CTL);
  assign dat_wr = reg_we && (reg_addr == RA_DAT);

  twi_mstx_rate u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sel       (rate_q),
    .ovf_tick  (ovf_tick),
    .half_tick (half_tick)
  );

  twi_mstx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .sta       (sta_q),
    .sto       (sto_q),
    .flag      (flag_q),
    .tx_byte   (dat_q),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .half_tick (half_tick),
    .run       (run),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .set_flag  (set_flag),
    .set_code  (set_code),
    .stop_done (stop_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      en_q   <= 1'b0;
      sta_q  <= 1'b0;
      sto_q  <= 1'b0;
      aa_q   <= 1'b0;
      flag_q <= 1'b0;
      dat_q  <= '0;
      code_q <= SC_NONE;
    end else begin
      if (stop_done) sto_q <= 1'b0;
      if (!en_q)     flag_q <= 1'b0;
      if (ctl_wr) begin
        rate_q <= reg_wdata[7:5];
        en_q   <= reg_wdata[4];
        sta_q  <= reg_wdata[3];
        sto_q  <= reg_wdata[2];
        aa_q   <= reg_wdata[1];
        if (!reg_wdata[0]) flag_q <= 1'b0;
      end
      if (dat_wr) dat_q <= reg_wdata;
      if (set_flag) begin
        flag_q <= 1'b1;
        code_q <= set_code;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTL:  reg_rdata = {rate_q, en_q, sta_q, sto_q, aa_q, flag_q};
      RA_DAT:  reg_rdata = dat_q;
      RA_STAT: reg_rdata = flag_q ? code_q : SC_NONE;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = flag_q;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> scl_drive_low) else $error("SCL released while flag pending");

  // R7
  sto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && !ctl_wr) |=> !sto_q) else $error("stop bit not cleared");

  // R11
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_q)) else $error("flag set while disabled");

endmodule

// File: tb/twi_mstx_bench.sv
module twi_mstx_bench;

  localparam int CLK_P   = 10;
  localparam int TICK_N  = 2;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0, ovf_tick = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, m_scl_low, m_sda_low;
  logic ext_scl_low = 1'b0, s_sda_low = 1'b0;
  logic scl, sda;

  assign scl = !(m_scl_low || ext_scl_low);
  assign sda = !(m_sda_low || s_sda_low);

  twi_mstx u_twi_mstx (
    .clk(clk), .rst_n(rst_n), .ovf_tick(ovf_tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl), .sda_in(sda),
    .scl_drive_low(m_scl_low), .sda_drive_low(m_sda_low)
  );

  always #(CLK_P/2) clk = !clk;

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TICK_N;
    ovf_tick = (tcnt == 0);
  end

  int n_chk = 0, n_bad = 0;
  int starts = 0, stops = 0, nlog = 0, exp_starts = 0, exp_stops = 0;
  logic [7:0] slv_last = 8'h00, sreg = 8'h00;
  int scnt = 0;
  logic sfirst = 1'b0, nack_data = 1'b0, scl_q = 1'b1, sda_q = 1'b1;

  // behavioural receiver
  always @(posedge clk) begin
    if (rst_n) begin
      if (scl && scl_q && sda_q && !sda) begin starts++; scnt = 0; sfirst = 1'b1; end
      else if (scl && scl_q && !sda_q && sda) begin stops++; scnt = 0; end
      else if (!scl_q && scl) begin
        if (scnt < 8) sreg = {sreg[6:0], sda};
        scnt++;
      end else if (scl_q && !scl) begin
        if (scnt == 8) begin
          slv_last = sreg; nlog++;
          s_sda_low <= sfirst ? (sreg[7:1] == SLV) : !nack_data;
        end else if (scnt == 9) begin
          s_sda_low <= 1'b0; scnt = 0; sfirst = 1'b0;
        end
      end
      scl_q = scl; sda_q = sda;
    end
  end

  int run_hi = 0, last_hi = 0;
  always @(negedge clk) begin
    if (scl) run_hi++;
    else if (run_hi > 0) begin last_hi = run_hi; run_hi = 0; end
  end

  function automatic int exp_half(input int code);
    int divs [7] = '{128, 112, 96, 80, 480, 60, 30};
    if (code == 7) return 48 * TICK_N;
    return divs[code] / 2;
  endfunction

  function automatic logic [7:0] cv(input int rate, input bit s, input bit p);
    return {rate[2:0], 1'b1, s, p, 1'b1, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic do_stop(input int rate);
    logic [7:0] v;
    int s0;
    s0 = stops;
    wr(2'd0, cv(rate, 0, 1));
    v = 8'h04;
    for (int k = 0; k < 5000 && v[2]; k++) rd(2'd0, v);
    repeat (4) @(negedge clk);
    exp_stops++;
    chk("R7 stop bit auto-clear", v[2], 0);
    chk("R7 one STOP edge", stops - s0, 1);
    rd(2'd2, v);
    chk("R7 status after stop", v, 8'hF8);
    chk("R7 lines released", {scl, sda, irq}, 3'b110);
  endtask

  task automatic start_addr(input int rate, input logic [6:0] a, input bit expect_rs);
    logic [7:0] v;
    wait_irq(); rd(2'd2, v);
    exp_starts++;
    chk(expect_rs ? "R6 repeated start code" : "R2 start code", v, expect_rs ? 8'h10 : 8'h08);
    wr(2'd1, {a, 1'b0});
    wr(2'd0, cv(rate, 0, 0));
    wait_irq(); rd(2'd2, v);
    chk("R3 address status", v, (a == SLV) ? 8'h18 : 8'h20);
    chk("R3 address bits MSB first", slv_last, {a, 1'b0});
    chk(rate == 7 ? "R10 high phase" : "R9 high phase", last_hi, exp_half(rate));
  endtask

  task automatic xfer(input int rate, input logic [6:0] a, input int nd, input bit nk_last);
    logic [7:0] v, b;
    wr(2'd0, cv(rate, 1, 0));
    start_addr(rate, a, 1'b0);
    if (a == SLV) begin
      for (int i = 0; i < nd; i++) begin
        b = 8'($urandom);
        nack_data = nk_last && (i == nd - 1);
        wr(2'd1, b);
        wr(2'd0, cv(rate, 0, 0));
        wait_irq(); rd(2'd2, v);
        chk("R4 data status", v, nack_data ? 8'h30 : 8'h28);
        chk("R4 data byte", slv_last, b);
      end
    end
    nack_data = 1'b0;
    do_stop(rate);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0, n0;
    void'($urandom(32'd20417));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd2, v); chk("R1 status reset", v, 8'hF8);
    chk("R1 irq and lines", {irq, scl, sda}, 3'b011);

    // R11: start while disabled, flag write of 1
    wr(2'd0, 8'h08);
    repeat (300) @(negedge clk);
    chk("R11 disabled start ignored", {irq, 8'(starts)}, {1'b0, 8'd0});
    wr(2'd0, 8'h11);
    repeat (20) @(negedge clk);
    chk("R11 flag write 1 ignored", irq, 0);

    // R2: busy bus delays START
    ext_scl_low = 1'b1;
    wr(2'd0, cv(0, 1, 0));
    repeat (300) @(negedge clk);
    chk("R2 no start on busy bus", {irq, 8'(starts)}, {1'b0, 8'd0});
    ext_scl_low = 1'b0;
    wait_irq(); rd(2'd2, v); exp_starts++;
    chk("R2 start code after bus free", v, 8'h08);
    do_stop(0);

    // R5: stall with flag pending
    wr(2'd0, cv(5, 1, 0));
    start_addr(5, SLV, 1'b0);
    n0 = nlog;
    repeat (200) @(negedge clk);
    rd(2'd2, v);
    chk("R5 status frozen", v, 8'h18);
    chk("R5 SCL held low and no bits", {scl, 8'(nlog - n0)}, {1'b0, 8'd0});
    // R6: repeated start
    wr(2'd0, cv(5, 1, 0));
    start_addr(5, SLV, 1'b1);
    // R8: stop and start together
    s0 = stops;
    wr(2'd0, cv(5, 1, 1));
    wait_irq(); rd(2'd2, v);
    exp_stops++; exp_starts++;
    chk("R8 stop before start", stops - s0, 1);
    chk("R8 new start code", v, 8'h08);
    do_stop(5);

    // R9 / R10: every rate code
    for (int c = 0; c < 8; c++) xfer(c, SLV, 1, 1'b0);

    // random traffic
    for (int t = 0; t < 6; t++)
      xfer(int'($urandom % 8), ($urandom % 4 == 0) ? 7'h33 : SLV,
           int'($urandom % 3), 1'($urandom % 2));

    // R12: no spurious START/STOP edges on the bus
    chk("R12 START edge count", starts, exp_starts);
    chk("R12 STOP edge count", stops, exp_stops);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule